// File: doc/BRIEF.md
# Rail-Clamped Offset PWM Modulator for a Seven-Switch Bridge

This block turns three signed phase voltage references into gate commands for a three-phase two-level bridge that also has a seventh switch in series with one DC-link rail. It works out one common offset and adds it to all three references. In positive-rail mode this pins the highest modified reference to +half the DC link. In negative-rail mode it pins the lowest modified reference to −half. As a result each switching period contains only one kind of zero vector. In positive-rail mode that is all uppers on (111). In negative-rail mode it is all lowers on (000). The seventh switch opens for the whole of that zero vector, which cuts the bridge off the DC source and lowers the common-mode voltage seen by the load.

A symmetric up/down carrier spans the DC-link range in the same signed units as the references. Each leg's upper gate is its modified reference compared against the carrier. The matching lower gate is the complement, with a dead-time gap placed only on the phase legs. The seventh-switch gate is the undelayed comparison of the carrier with the extreme modified reference. References, DC-link scale and rail mode are sampled once per period, at the carrier peak. A change mid-period therefore never shortens a pulse.

Top module: `h7_offset_pwm`

## Requirements
- R1: While `rst` is high, and after release until the first period has been sampled, every phase gate and `gate_s7` is low.
- R2: With `neg_rail`=0, the offset is `dc_half` minus the largest reference. The largest modified reference equals +`dc_half`, so its upper gate stays on all period and no cycle has all three lower gates on.
- R3: With `neg_rail`=1, the offset is −`dc_half` minus the smallest reference. The smallest modified reference equals −`dc_half`, so its lower gate stays on all period and no cycle has all three upper gates on.
- R4: The carrier moves by one per clock between −`dc_half` and `dc_half`−1, so a period lasts 4·`dc_half`−2 clocks. A leg's undelayed upper command is on when its modified reference m is greater than the carrier. Over a period that gives 2(m+h) − [m>−h] − [m>h−1] on-cycles, with h=`dc_half`.
- R5: The two gates of a leg are never on together. Every change of the leg command is followed by DEAD clocks (default 4) with both gates off. Each toggling leg therefore loses DEAD cycles from both its upper and its lower on-time per period.
- R6: With `neg_rail`=0, `gate_s7` is on exactly when the carrier is greater than or equal to the smallest modified reference. While it is off, no lower gate is on.
- R7: With `neg_rail`=1, `gate_s7` is on exactly when the carrier is less than the largest modified reference. While it is off, no upper gate is on.
- R8: `gate_s7` has no dead time. Its on-cycles per period equal the ideal comparison count exactly.
- R9: References, `dc_half` and `neg_rail` are sampled only at the carrier peak. Changes that come and go between two peaks leave every gate unchanged.
- R10: Modified references are saturated to ±`dc_half`. A reference pushed below −`dc_half` yields a leg that is never on in the upper position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| neg_rail | input | 1 | 0: seventh switch on positive rail; 1: on negative rail |
| dc_half | input | REF_W-1 | Half the DC-link value in reference units (at least 2) |
| ref_a | input | REF_W | Signed phase A reference |
| ref_b | input | REF_W | Signed phase B reference |
| ref_c | input | REF_W | Signed phase C reference |
| gate_hi | output | 3 | Upper gates, bit 0 = phase A, bit 2 = phase C |
| gate_lo | output | 3 | Lower gates, same bit order |
| gate_s7 | output | 1 | Seventh (DC-link disconnect) switch gate, 1 = closed |

## Verification
The hardest situation to reach from the ports is an input change that lands strictly between two carrier peaks. The carrier phase is not visible at the ports. The bench therefore resets the block, which puts the first sample on the first clock edge. From there the next peak falls a fixed number of edges later. A short pulse on a reference, on the rail mode and on the scale is placed well inside that first period. The gate on-counts over two periods are then compared with an identical run that has no pulse. All other vectors are judged by per-period on-counts worked out from the carrier shape, after waiting long enough for both the old and the new period to run out.

// File: rtl/h7_offset_pwm.sv
module h7_offset_pwm #(
  parameter int REF_W = 16,
  parameter int DEAD  = 4
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    neg_rail,
  input  logic [REF_W-2:0]        dc_half,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  output logic [2:0]              gate_hi,
  output logic [2:0]              gate_lo,
  output logic                    gate_s7
);
  localparam int W    = REF_W + 2;
  localparam int DT_W = $clog2(DEAD + 2);

  logic signed [W-1:0] in_ref [3];
  logic signed [W-1:0] in_half, in_max, in_min, offset;
  logic signed [W-1:0] next_mod [3];

  assign in_ref[0] = W'(ref_a);
  assign in_ref[1] = W'(ref_b);
  assign in_ref[2] = W'(ref_c);
  assign in_half   = W'(signed'({1'b0, dc_half}));

  always_comb begin
    in_max = in_ref[0];
    in_min = in_ref[0];
    for (int i = 1; i < 3; i++) begin
      if (in_ref[i] > in_max) in_max = in_ref[i];
      if (in_ref[i] < in_min) in_min = in_ref[i];
    end
  end

  assign offset = neg_rail ? (-in_half - in_min) : (in_half - in_max);

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      next_mod[i] = in_ref[i] + offset;
      if (next_mod[i] > in_half)       next_mod[i] = in_half;
      else if (next_mod[i] < -in_half) next_mod[i] = -in_half;
    end
  end

  logic signed [W-1:0] mod_r [3];
  logic signed [W-1:0] half_r, car, lat_max, lat_min;
  logic                neg_r, active, active_d, dir_up, boundary;

  assign boundary = dir_up && (car >= half_r - W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      car      <= '0;
      dir_up   <= 1'b1;
      half_r   <= '0;
      neg_r    <= 1'b0;
      active   <= 1'b0;
      active_d <= 1'b0;
      for (int i = 0; i < 3; i++) mod_r[i] <= '0;
    end else begin
      active_d <= active;
      if (boundary) begin
        half_r <= in_half;
        neg_r  <= neg_rail;
        active <= 1'b1;
        for (int i = 0; i < 3; i++) mod_r[i] <= next_mod[i];
        car    <= in_half - W'(2);
        dir_up <= 1'b0;
      end else if (dir_up) begin
        car <= car + W'(1);
      end else if (car <= -half_r) begin
        car    <= car + W'(1);
        dir_up <= 1'b1;
      end else begin
        car <= car - W'(1);
      end
    end
  end

  always_comb begin
    lat_max = mod_r[0];
    lat_min = mod_r[0];
    for (int i = 1; i < 3; i++) begin
      if (mod_r[i] > lat_max) lat_max = mod_r[i];
      if (mod_r[i] < lat_min) lat_min = mod_r[i];
    end
  end

  logic [2:0]      raw, raw_q;
  logic            raw_s7, s7_q;
  logic [DT_W-1:0] dt [3];

  always_comb
    for (int i = 0; i < 3; i++) raw[i] = active && (mod_r[i] > car);

  assign raw_s7 = active && (neg_r ? (car < lat_max) : (car >= lat_min));

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      s7_q  <= 1'b0;
      for (int i = 0; i < 3; i++) dt[i] <= '0;
    end else begin
      s7_q <= raw_s7;
      for (int i = 0; i < 3; i++) begin
        if (raw[i] != raw_q[i]) begin
          raw_q[i] <= raw[i];
          dt[i]    <= DT_W'(DEAD);
        end else if (dt[i] != '0) begin
          dt[i] <= dt[i] - 1'b1;
        end
      end
    end
  end

  always_comb
    for (int i = 0; i < 3; i++) begin
      gate_hi[i] = raw_q[i] && (dt[i] == '0);
      gate_lo[i] = active_d && !raw_q[i] && (dt[i] == '0);
    end

  assign gate_s7 = s7_q;

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !active_d |-> (gate_hi == 3'b000 && gate_lo == 3'b000 && !gate_s7));

  p_leg_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  p_zero_pos_r2: assert property (@(posedge clk) disable iff (rst)
    (active_d && !neg_r && !$past(neg_r) && !$past(neg_r, 2)) |-> !(&gate_lo));

  p_zero_neg_r3: assert property (@(posedge clk) disable iff (rst)
    (active_d && neg_r && $past(neg_r) && $past(neg_r, 2)) |-> !(&gate_hi));

  p_s7_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (active_d && !gate_s7 && !neg_r && !$past(neg_r) && !$past(neg_r, 2))
      |-> (gate_lo == 3'b000));

  p_s7_neg_r7: assert property (@(posedge clk) disable iff (rst)
    (active_d && !gate_s7 && neg_r && $past(neg_r) && $past(neg_r, 2))
      |-> (gate_hi == 3'b000));

  p_car_range_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> (car >= -half_r && car <= half_r - W'(1)));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(mod_r[0]) && $stable(mod_r[1]) && $stable(mod_r[2])
                   && $stable(neg_r) && $stable(half_r)));
endmodule

// File: tb/h7_offset_pwm_tb.sv
`timescale 1ns/1ps
module h7_offset_pwm_tb;
  localparam int REF_W = 16;
  localparam int DEAD  = 4;

  typedef struct packed { logic neg; int half; int a; int b; int c; } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0,   20,  10,  -5, -15},
    '{1'b0,   20,   0,   0,   0},
    '{1'b1,   20,  10,  -5, -15},
    '{1'b0,   30,-100, 200,   0},
    '{1'b1,   12,   5,   5,  -7},
    '{1'b0,   12,  -7,   3,   3},
    '{1'b1, 1000, 300,-700,   0}
  };

  logic clk = 0, rst = 1, neg_rail = 0;
  logic [REF_W-2:0] dc_half = '0;
  logic signed [REF_W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [2:0] gate_hi, gate_lo;
  logic gate_s7;

  h7_offset_pwm #(.REF_W(REF_W), .DEAD(DEAD)) u_dut (
    .clk(clk), .rst(rst), .neg_rail(neg_rail), .dc_half(dc_half),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .gate_s7(gate_s7));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  bit mon_on = 0, cur_neg = 0;
  int v_excl = 0, v_zero = 0, v_s7 = 0;
  int c_hi [3], c_lo [3], c_s7;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v, input int h);
    if (v > h) return h;
    if (v < -h) return -h;
    return v;
  endfunction

  function automatic int above(input int m, input int h);
    int k = 2 * (m + h);
    if (m > -h) k--;
    if (m > h - 1) k--;
    return k;
  endfunction

  function automatic int hi_exp(input int cnt, input int p);
    if (cnt == 0 || cnt == p) return cnt;
    return cnt - DEAD;
  endfunction

  function automatic int lo_exp(input int cnt, input int p);
    if (cnt == 0 || cnt == p) return p - cnt;
    return p - cnt - DEAD;
  endfunction

  always @(negedge clk) if (mon_on) begin
    if ((gate_hi & gate_lo) != 3'b000) v_excl++;
    if (!cur_neg && &gate_lo) v_zero++;
    if (cur_neg && &gate_hi) v_zero++;
    if (!cur_neg && !gate_s7 && |gate_lo) v_s7++;
    if (cur_neg && !gate_s7 && |gate_hi) v_s7++;
  end

  task automatic apply(input vec_t v);
    neg_rail = v.neg;
    dc_half  = (REF_W-1)'(v.half);
    ref_a    = REF_W'(v.a);
    ref_b    = REF_W'(v.b);
    ref_c    = REF_W'(v.c);
  endtask

  task automatic count_window(input int n);
    for (int i = 0; i < 3; i++) begin c_hi[i] = 0; c_lo[i] = 0; end
    c_s7 = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        c_hi[i] += int'(gate_hi[i]);
        c_lo[i] += int'(gate_lo[i]);
      end
      c_s7 += int'(gate_s7);
    end
  endtask

  task automatic run_latch(input bit pulse, output int hb, output int lb, output int sb);
    rst = 1;
    apply(VECS[0]);
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    hb = 0; lb = 0; sb = 0;
    for (int cyc = 0; cyc < 2 * 78; cyc++) begin
      @(negedge clk);
      hb += int'(gate_hi[1]);
      lb += int'(gate_lo[1]);
      sb += int'(gate_s7);
      if (pulse && cyc == 38) begin
        ref_b = 16'sd19; neg_rail = 1'b1; dc_half = 15'd30;
      end
      if (pulse && cyc == 41) apply(VECS[0]);
    end
  endtask

  initial begin
    int prev_p;
    int hb0, lb0, sb0, hb1, lb1, sb1;
    apply(VECS[0]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 gates during reset", int'({gate_hi, gate_lo, gate_s7}), 0);
    rst = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 gates before first sampled period", int'({gate_hi, gate_lo, gate_s7}), 0);
    repeat (DEAD + 3) @(negedge clk);
    chk("R2 largest-reference upper gate on", int'(gate_hi[0]), 1);

    prev_p = 4 * VECS[0].half - 2;
    for (int v = 0; v < NV; v++) begin
      int h, p, mx, mn, off, cnt_min, cnt_max;
      int r [3], m [3], cn [3];
      h = VECS[v].half;
      p = 4 * h - 2;
      r[0] = VECS[v].a; r[1] = VECS[v].b; r[2] = VECS[v].c;
      mx = r[0]; mn = r[0];
      for (int i = 1; i < 3; i++) begin
        if (r[i] > mx) mx = r[i];
        if (r[i] < mn) mn = r[i];
      end
      off = VECS[v].neg ? (-h - mn) : (h - mx);
      for (int i = 0; i < 3; i++) begin
        m[i]  = sat(r[i] + off, h);
        cn[i] = above(m[i], h);
      end
      cnt_min = cn[0]; cnt_max = cn[0];
      for (int i = 1; i < 3; i++) begin
        if (cn[i] < cnt_min) cnt_min = cn[i];
        if (cn[i] > cnt_max) cnt_max = cn[i];
      end
      @(negedge clk);
      apply(VECS[v]);
      repeat (prev_p + 2 * p + 4) @(posedge clk);
      cur_neg = VECS[v].neg;
      mon_on = 1;
      count_window(p);
      mon_on = 0;
      for (int i = 0; i < 3; i++) begin
        chk($sformatf("R4 R10 vec%0d leg%0d upper on-cycles", v, i), c_hi[i], hi_exp(cn[i], p));
        chk($sformatf("R5 vec%0d leg%0d lower on-cycles", v, i), c_lo[i], lo_exp(cn[i], p));
      end
      if (VECS[v].neg)
        chk($sformatf("R7 R8 vec%0d seventh on-cycles", v), c_s7, cnt_max);
      else
        chk($sformatf("R6 R8 vec%0d seventh on-cycles", v), c_s7, p - cnt_min);
      prev_p = p;
    end

    chk("R5 upper and lower never together", v_excl, 0);
    chk("R2 R3 single zero vector kind", v_zero, 0);
    chk("R6 R7 seventh open only in zero vector", v_s7, 0);

    run_latch(1'b0, hb0, lb0, sb0);
    run_latch(1'b1, hb1, lb1, sb1);
    chk("R9 mid-period change: upper gate", hb1, hb0);
    chk("R9 mid-period change: lower gate", lb1, lb0);
    chk("R9 mid-period change: seventh gate", sb1, sb0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule